// File: doc/BRIEF.md
# Pin Port with Per-Pin Interrupt Sensing

This block is one 32-pin general-purpose I/O port that sits on a simple 32-bit register bus. Software can set an output value and a direction for each pin. It can read back the synchronized level of every pin, and it can give each pin a 2-bit sense code that picks one of four trigger conditions: low level, high level, rising edge or falling edge. When a pin's condition is met, its bit in a pending register is set and stays set. Software clears a pending bit by writing a one to it.

A per-pin enable register gates the pending bits onto one interrupt line. The pin inputs are brought into the clock domain by a two-stage synchronizer before any sampling or sensing is done. Each pin's sense code is packed two bits per pin: pins 0 to 15 are in the lower sense register and pins 16 to 31 are in the upper one. The bus reads combinationally. A write takes effect on the clock edge at which `bus_we_i` is high.

Top module: `gpio_sense_port`

## Requirements
- R1: Writing offset 0x00 sets the output value register and writing offset 0x04 sets the direction register. `pin_out_o` follows the value register and `pin_oe_o` follows the direction register, so a direction bit of 1 drives that pin as an output. Both registers read back at their offsets.
- R2: A read of offset 0x08 returns the synchronized level of all pins, whatever their direction. It reflects a pin change within three clock cycles. Writes to 0x08 have no effect.
- R3: Sense code 0 sets a pin's pending bit on every cycle in which its synchronized level is 0.
- R4: Sense code 1 sets a pin's pending bit on every cycle in which its synchronized level is 1.
- R5: Sense code 2 sets a pin's pending bit once, when its synchronized level goes from 0 to 1.
- R6: Sense code 3 sets a pin's pending bit once, when its synchronized level goes from 1 to 0.
- R7: Pin n takes its sense code from bits [2*(n mod 16)+1 : 2*(n mod 16)]. For pins 0–15 these bits are in the lower sense register at offset 0x0C. For pins 16–31 they are in the upper sense register at offset 0x10.
- R8: The pending register at offset 0x18 reads back the pending bits. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged.
- R9: If a pin's condition holds in the same cycle that a clear hits its pending bit, the bit stays set. A pin whose level condition persists therefore remains pending after a clear.
- R10: `irq_o` is high exactly when some pending bit has its enable bit (offset 0x14, 1 = enabled) set.
- R11: After reset, the value, direction, both sense registers and the enable register read as zero. `pin_oe_o` is zero and `irq_o` is low.
- R12: Reads of any offset other than the seven mapped ones return zero. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr_i | input | 8 | Byte offset of the register being accessed |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| pin_in_i | input | 32 | Pin levels from the pads |
| pin_out_o | output | 32 | Output values to the pads |
| pin_oe_o | output | 32 | Output enables to the pads, 1 = drive |
| irq_o | output | 1 | Interrupt request |

## Verification
A pin's trigger condition and a software clear can hit the same pending bit in the same cycle. The bench provokes this by holding a pin at its triggering level under a level sense code and then writing a one to that pending bit. It judges the outcome from the read-back: the bit must still be pending. It then checks the opposite case: once the level is removed, the same clear must leave the bit empty. Edge-sensed pins are checked the same way, to show that a single clear removes an event that does not repeat.

// File: rtl/gpio_sense_pkg.sv
package gpio_sense_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_HIGH = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_FALL = 2'd3
  } sense_e;

  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_VALUE   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DIR     = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_LEVEL   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_SENSE_L = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_SENSE_H = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_ENABLE  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_PEND    = 8'h18;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] lvl_prev_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] lvl_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl_o      = lvl_q;
  assign lvl_prev_o = prev_q;

endmodule

// File: rtl/gpio_sense_decode.sv
module gpio_sense_decode
  import gpio_sense_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] sense_lo_i,
  input  logic [DATA_W-1:0] sense_hi_i,
  input  logic [NPINS-1:0]  lvl_i,
  input  logic [NPINS-1:0]  lvl_prev_i,
  output logic [NPINS-1:0]  evt_o
);

  localparam int unsigned PINS_PER_REG = DATA_W / 2;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int unsigned SLOT = p % PINS_PER_REG;
    localparam bit          UPPER = (p >= PINS_PER_REG);

    sense_e code;

    if (UPPER) begin : g_hi
      assign code = sense_e'(sense_hi_i[2*SLOT +: 2]);
    end else begin : g_lo
      assign code = sense_e'(sense_lo_i[2*SLOT +: 2]);
    end

    always_comb begin
      unique case (code)
        SENSE_LOW:  evt_o[p] = ~lvl_i[p];
        SENSE_HIGH: evt_o[p] =  lvl_i[p];
        SENSE_RISE: evt_o[p] =  lvl_i[p] & ~lvl_prev_i[p];
        SENSE_FALL: evt_o[p] = ~lvl_i[p] &  lvl_prev_i[p];
        default:    evt_o[p] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] evt_i,
  input  logic             clr_en_i,
  input  logic [NPINS-1:0] clr_bits_i,
  input  logic [NPINS-1:0] enable_i,
  output logic [NPINS-1:0] pend_o,
  output logic             irq_o
);

  logic [NPINS-1:0] pend_q;
  logic [NPINS-1:0] pend_d;
  logic [NPINS-1:0] clr_eff;

  always_comb begin
    clr_eff = clr_en_i ? clr_bits_i : '0;
    // a new event beats a clear in the same cycle
    pend_d  = (pend_q & ~clr_eff) | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & enable_i);

endmodule

// File: rtl/gpio_sense_port.sv
module gpio_sense_port
  import gpio_sense_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [NPINS-1:0]  pin_in_i,
  output logic [NPINS-1:0]  pin_out_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  // write decode
  logic wr_value, wr_dir, wr_sense_lo, wr_sense_hi, wr_enable, wr_pend;

  always_comb begin
    wr_value    = bus_we_i && (bus_addr_i == OFF_VALUE);
    wr_dir      = bus_we_i && (bus_addr_i == OFF_DIR);
    wr_sense_lo = bus_we_i && (bus_addr_i == OFF_SENSE_L);
    wr_sense_hi = bus_we_i && (bus_addr_i == OFF_SENSE_H);
    wr_enable   = bus_we_i && (bus_addr_i == OFF_ENABLE);
    wr_pend     = bus_we_i && (bus_addr_i == OFF_PEND);
  end

  // software registers: next state
  logic [NPINS-1:0]  value_q,    value_d;
  logic [NPINS-1:0]  dir_q,      dir_d;
  logic [DATA_W-1:0] sense_lo_q, sense_lo_d;
  logic [DATA_W-1:0] sense_hi_q, sense_hi_d;
  logic [NPINS-1:0]  enable_q,   enable_d;

  always_comb begin
    value_d    = value_q;
    dir_d      = dir_q;
    sense_lo_d = sense_lo_q;
    sense_hi_d = sense_hi_q;
    enable_d   = enable_q;
    if (wr_value)    value_d    = bus_wdata_i[NPINS-1:0];
    if (wr_dir)      dir_d      = bus_wdata_i[NPINS-1:0];
    if (wr_sense_lo) sense_lo_d = bus_wdata_i;
    if (wr_sense_hi) sense_hi_d = bus_wdata_i;
    if (wr_enable)   enable_d   = bus_wdata_i[NPINS-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      value_q    <= '0;
      dir_q      <= '0;
      sense_lo_q <= '0;
      sense_hi_q <= '0;
      enable_q   <= '0;
    end else begin
      value_q    <= value_d;
      dir_q      <= dir_d;
      sense_lo_q <= sense_lo_d;
      sense_hi_q <= sense_hi_d;
      enable_q   <= enable_d;
    end
  end

  // input path
  logic [NPINS-1:0] lvl;
  logic [NPINS-1:0] lvl_prev;
  logic [NPINS-1:0] evt;
  logic [NPINS-1:0] pend_q;

  gpio_pin_sync #(
    .WIDTH (NPINS)
  ) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .d_i        (pin_in_i),
    .lvl_o      (lvl),
    .lvl_prev_o (lvl_prev)
  );

  gpio_sense_decode #(
    .NPINS  (NPINS),
    .DATA_W (DATA_W)
  ) u_sense (
    .sense_lo_i (sense_lo_q),
    .sense_hi_i (sense_hi_q),
    .lvl_i      (lvl),
    .lvl_prev_i (lvl_prev),
    .evt_o      (evt)
  );

  gpio_irq_status #(
    .NPINS (NPINS)
  ) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .evt_i      (evt),
    .clr_en_i   (wr_pend),
    .clr_bits_i (bus_wdata_i[NPINS-1:0]),
    .enable_i   (enable_q),
    .pend_o     (pend_q),
    .irq_o      (irq_o)
  );

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      OFF_VALUE:   bus_rdata_o[NPINS-1:0] = value_q;
      OFF_DIR:     bus_rdata_o[NPINS-1:0] = dir_q;
      OFF_LEVEL:   bus_rdata_o[NPINS-1:0] = lvl;
      OFF_SENSE_L: bus_rdata_o            = sense_lo_q;
      OFF_SENSE_H: bus_rdata_o            = sense_hi_q;
      OFF_ENABLE:  bus_rdata_o[NPINS-1:0] = enable_q;
      OFF_PEND:    bus_rdata_o[NPINS-1:0] = pend_q;
      default:     bus_rdata_o            = '0;
    endcase
  end

  assign pin_out_o = value_q;
  assign pin_oe_o  = dir_q;

endmodule

// File: rtl/gpio_sense_port_chk.sv
module gpio_sense_port_chk
  import gpio_sense_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic [7:0]        bus_addr_i,
  input logic              bus_we_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [NPINS-1:0]  pin_oe_o,
  input logic              irq_o,
  input logic [NPINS-1:0]  value_q,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  enable_q,
  input logic [NPINS-1:0]  pend_q,
  input logic [DATA_W-1:0] sense_lo_q,
  input logic [NPINS-1:0]  lvl,
  input logic [NPINS-1:0]  lvl_prev,
  input logic [NPINS-1:0]  evt
);

  logic unmapped;
  assign unmapped = !(bus_addr_i inside {OFF_VALUE, OFF_DIR, OFF_LEVEL, OFF_SENSE_L,
                                         OFF_SENSE_H, OFF_ENABLE, OFF_PEND});

  AST_DIR_DRIVES_OE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_we_i && bus_addr_i == OFF_DIR) |=> (pin_oe_o == $past(bus_wdata_i[NPINS-1:0]))); // R1

  AST_HIGH_LEVEL_SETS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sense_lo_q[1:0] == 2'd1 && lvl[0]) |=> pend_q[0]); // R4

  AST_RISE_SETS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sense_lo_q[5:4] == 2'd2 && lvl[2] && !lvl_prev[2]) |=> pend_q[2]); // R5

  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_we_i && bus_addr_i == OFF_PEND && bus_wdata_i[0] && !evt[0]) |=> !pend_q[0]); // R8

  AST_NO_ENABLE_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_n)
    (enable_q == '0) |-> !irq_o); // R10

  AST_UNMAPPED_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_we_i && unmapped) |=> ($stable(value_q) && $stable(dir_q) && $stable(enable_q))); // R12

endmodule

bind gpio_sense_port gpio_sense_port_chk #(
  .NPINS  (NPINS),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_sync_n),
  .bus_addr_i  (bus_addr_i),
  .bus_we_i    (bus_we_i),
  .bus_wdata_i (bus_wdata_i),
  .pin_oe_o    (pin_oe_o),
  .irq_o       (irq_o),
  .value_q     (value_q),
  .dir_q       (dir_q),
  .enable_q    (enable_q),
  .pend_q      (pend_q),
  .sense_lo_q  (sense_lo_q),
  .lvl         (lvl),
  .lvl_prev    (lvl_prev),
  .evt         (evt)
);

// File: tb/gpio_sense_port_tb.sv
`timescale 1ns/1ps
module gpio_sense_port_tb;

  localparam logic [7:0] A_VAL = 8'h00, A_DIR = 8'h04, A_LVL = 8'h08, A_SLO = 8'h0C,
                         A_SHI = 8'h10, A_ENA = 8'h14, A_PND = 8'h18;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic        irq;

  always #2.5 clk = ~clk;

  gpio_sense_port u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_addr_i  (bus_addr),
    .bus_we_i    (bus_we),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .pin_in_i    (pin_in),
    .pin_out_o   (pin_out),
    .pin_oe_o    (pin_oe),
    .irq_o       (irq)
  );

  typedef struct {
    int          kind;   // 0 read data, 1 pin_out, 2 pin_oe, 3 irq
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  event  sample_ev;
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    finished = 1'b0;

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0: act = bus_rdata;
          1: act = pin_out;
          2: act = pin_oe;
          default: act = {31'd0, irq};
        endcase
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %08h expected %08h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_port(input int kind, input logic [7:0] addr,
                             input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    bus_we   = 1'b0;
    bus_addr = addr;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    #1 -> sample_ev;
    #0;
  endtask

  task automatic rd(input logic [7:0] addr, input logic [31:0] exp, input string tag);
    expect_port(0, addr, exp, tag);
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    bus_addr  = addr;
    bus_wdata = data;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
    bus_addr  = 8'hFC;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  logic [31:0] slo, shi, pat;

  initial begin
    rst_n     = 1'b0;
    bus_addr  = 8'hFC;
    bus_we    = 1'b0;
    bus_wdata = '0;
    pin_in    = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R11 reset state
    rd(A_VAL, 32'h0, "R11 value reg");
    rd(A_DIR, 32'h0, "R11 dir reg");
    rd(A_SLO, 32'h0, "R11 sense lo");
    rd(A_SHI, 32'h0, "R11 sense hi");
    rd(A_ENA, 32'h0, "R11 enable reg");
    expect_port(2, 8'hFC, 32'h0, "R11 pin_oe");
    expect_port(3, 8'hFC, 32'h0, "R11 irq");

    // everything rising-edge, then clear the level-triggered backlog
    slo = 32'hAAAA_AAAA; shi = 32'hAAAA_AAAA;
    wr(A_SLO, slo); wr(A_SHI, shi);
    settle();
    wr(A_PND, 32'hFFFF_FFFF);
    rd(A_PND, 32'h0, "R8 clear all");

    // R5 rising edge on pin 3
    pin_in[3] = 1'b1; settle();
    rd(A_PND, 32'h0000_0008, "R5 rise pin3");
    settle();
    rd(A_PND, 32'h0000_0008, "R5 single event held");
    wr(A_PND, 32'h0000_0008);
    rd(A_PND, 32'h0, "R5 edge cleared once");

    // R6/R7 falling edge on pin 20 (upper register, bits 9:8)
    shi = shi | (32'h3 << 8);
    wr(A_SHI, shi);
    pin_in[20] = 1'b1; settle();
    rd(A_PND, 32'h0, "R6 no event on rise in fall mode");
    pin_in[20] = 1'b0; settle();
    rd(A_PND, 32'h0010_0000, "R6 fall pin20");
    wr(A_PND, 32'h0010_0000);

    // R7 lower-register bits 9:8 are pin 4, not pin 20
    slo = (slo & ~(32'h3 << 8)) | (32'h1 << 8);
    wr(A_SLO, slo);
    settle();
    rd(A_PND, 32'h0, "R7 pin4 high-level idle, pin20 untouched");
    rd(A_SLO, slo, "R7 lower sense readback");
    rd(A_SHI, shi, "R7 upper sense readback");

    // R4 high level on pin 4, R9 clear loses to persistent level
    pin_in[4] = 1'b1; settle();
    rd(A_PND, 32'h0000_0010, "R4 high level pin4");
    wr(A_PND, 32'h0000_0010);
    rd(A_PND, 32'h0000_0010, "R9 set wins over clear");
    pin_in[4] = 1'b0; settle();
    wr(A_PND, 32'h0000_0010);
    rd(A_PND, 32'h0, "R9 clear after level removed");

    // R3 low level on pin 7 (bits 15:14 of lower register)
    slo = slo & ~(32'h3 << 14);
    wr(A_SLO, slo);
    settle();
    rd(A_PND, 32'h0000_0080, "R3 low level pin7");
    wr(A_PND, 32'h0);
    rd(A_PND, 32'h0000_0080, "R8 zero write leaves bit");

    // R10 enable gating
    wr(A_ENA, 32'h0000_0080);
    expect_port(3, 8'hFC, 32'h1, "R10 irq with enabled pending");
    wr(A_ENA, 32'h0000_0040);
    expect_port(3, 8'hFC, 32'h0, "R10 irq with other pin enabled");
    pin_in[7] = 1'b1; settle();
    wr(A_PND, 32'h0000_0080);
    rd(A_PND, 32'h0, "R3 clear after level gone");
    wr(A_ENA, 32'h0000_0080);
    expect_port(3, 8'hFC, 32'h0, "R10 irq with nothing pending");

    // R2 level read, read-only
    pat = 32'h5A3C_0098;
    pin_in = pat; settle();
    rd(A_LVL, pat, "R2 level read");
    wr(A_LVL, 32'h0);
    rd(A_LVL, pat, "R2 level ignores write");
    pin_in = 32'hFFFF_0000;
    repeat (4) @(negedge clk);
    rd(A_LVL, 32'hFFFF_0000, "R2 level tracks change");

    // R1 output value and direction
    wr(A_VAL, 32'hA5A5_0F0F);
    wr(A_DIR, 32'h0000_FFFF);
    expect_port(1, 8'hFC, 32'hA5A5_0F0F, "R1 pin_out");
    expect_port(2, 8'hFC, 32'h0000_FFFF, "R1 pin_oe");
    rd(A_VAL, 32'hA5A5_0F0F, "R1 value readback");
    rd(A_DIR, 32'h0000_FFFF, "R1 dir readback");

    // R12 unmapped offsets
    rd(8'h1C, 32'h0, "R12 unmapped read 0x1C");
    rd(8'h40, 32'h0, "R12 unmapped read 0x40");
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h1C, 32'h1234_5678);
    rd(A_VAL, 32'hA5A5_0F0F, "R12 value unchanged");
    rd(A_DIR, 32'h0000_FFFF, "R12 dir unchanged");
    rd(A_ENA, 32'h0000_0080, "R12 enable unchanged");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule